// File: doc/BRIEF.md
# Per-Core Bus Slot Request Scheduler

This block sits between a core's private cache controller and a shared bus that is divided into time slots, each slot owned by one core. The cache controller hands it two kinds of traffic. Coherence requests (read-shared, read-for-modify and upgrade) go into a request queue. Write-back data responses go into a separate write-back queue. When a slot opens and this core owns it, the block sends at most one message, taken from the head of one of the two queues.

The two queues take turns inside the core's own slots. The turn is time-conserving: an empty or ineligible queue gives the slot to the other queue. An upgrade caused by a write hit to a line that is not modified is only sent in an owned slot. It is also held back while the shared memory reports earlier pending requests to that line from other cores. The block shows the address at the head of the request queue to the shared memory, and the memory answers with a pending flag in the same cycle.

Top module: `slot_req_sched`

## Requirements
- R1: `bus_valid` is 1 in a cycle only if, in the cycle before, `slot_start` was 1 and `slot_owner` equalled the parameter `CORE_ID`. A slot owned by another core never produces a message.
- R2: One owned slot (one cycle with `slot_start` high) produces at most one message, one cycle later, and removes at most one entry from the two queues together.
- R3: Request-queue entries leave in the order they were pushed, with the kind and address they were pushed with. Kind codes on `pr_kind`/`bus_kind` are 0 read-shared, 1 read-for-modify and 2 upgrade.
- R4: Write-back entries leave in push order, and each goes out with `bus_kind` = 3 and its pushed address.
- R5: When both queues can send, owned slots alternate between them. After reset the request queue has the first turn, and after a send the turn passes to the other queue.
- R6: If the queue whose turn it is has nothing it may send, the other queue uses the slot. A non-empty write-back queue therefore always yields a message in an owned slot.
- R7: An upgrade at the head of the request queue is not sent in a slot where `query_pending` is 1. It stays at the head for a later slot, and a write-back may use that slot. A read-shared or read-for-modify head is not affected by `query_pending`.
- R8: An owned slot in which nothing is sent leaves the turn unchanged and produces no message.
- R9: Each queue holds 4 entries. Its full flag is 1 when it holds 4 entries, and a push while full is ignored.
- R10: When the request queue is not empty, `query_addr` equals the address of its head entry.
- R11: After reset `bus_valid`, `pr_full` and `wb_full` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_start | input | 1 | First cycle of a bus slot |
| slot_owner | input | ID_W | Id of the core owning the slot that starts |
| pr_push | input | 1 | Push a coherence request |
| pr_kind | input | 2 | Request kind: 0 read-shared, 1 read-for-modify, 2 upgrade |
| pr_addr | input | ADDR_W | Line address of the request |
| pr_full | output | 1 | Request queue full |
| wb_push | input | 1 | Push a write-back response |
| wb_addr | input | ADDR_W | Line address of the write-back |
| wb_full | output | 1 | Write-back queue full |
| query_addr | output | ADDR_W | Head request address shown to the shared memory |
| query_pending | input | 1 | Memory holds earlier pending requests to `query_addr` |
| bus_valid | output | 1 | A message is on the bus this cycle |
| bus_kind | output | 2 | Message kind, 3 for write-back |
| bus_addr | output | ADDR_W | Message line address |

## Verification
The hardest case to reach is a blocked upgrade. An owned slot must arrive while an upgrade sits at the request head and the memory reports a pending request. The bench reaches it twice: once with a write-back queued, which must take the slot, and once with the write-back queue empty, which must give an idle slot that leaves the turn unchanged. A later slot with the pending flag cleared then releases the upgrade, and the order of the following messages shows where the turn pointer stands. Filling both queues past capacity and draining them through alternating slots covers the full flags and the dropped pushes.

// File: rtl/srs_pkg.sv
package srs_pkg;
  typedef enum logic [1:0] {
    MSG_GETS = 2'd0,
    MSG_GETM = 2'd1,
    MSG_UPG  = 2'd2,
    MSG_WB   = 2'd3
  } msg_kind_e;
endpackage

// File: rtl/srs_fifo.sv
module srs_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] rd_q, rd_d, wr_q, wr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             do_push, do_pop;

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem_q[rd_q];

  always_comb begin
    rd_d  = rd_q;
    wr_d  = wr_q;
    cnt_d = cnt_q;
    if (do_pop)
      rd_d = (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    if (do_push)
      wr_d = (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    if (do_push && !do_pop)
      cnt_d = cnt_q + 1'b1;
    else if (do_pop && !do_push)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wr_q] <= din;
  end
endmodule

// File: rtl/srs_pick.sv
module srs_pick (
  input  logic clk,
  input  logic rst_n,
  input  logic grant,
  input  logic pr_ok,
  input  logic wb_ok,
  output logic send_pr,
  output logic send_wb
);
  // turn_q: 0 = request queue has the turn, 1 = write-back queue
  logic turn_q, turn_d;
  logic want_wb;

  assign want_wb = wb_ok && (turn_q || !pr_ok);
  assign send_wb = grant && want_wb;
  assign send_pr = grant && pr_ok && !want_wb;

  always_comb begin
    turn_d = turn_q;
    if (send_pr)      turn_d = 1'b1;
    else if (send_wb) turn_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) turn_q <= 1'b0;
    else        turn_q <= turn_d;
  end
endmodule

// File: rtl/slot_req_sched.sv
module slot_req_sched #(
  parameter int ID_W    = 2,
  parameter int CORE_ID = 0,
  parameter int ADDR_W  = 8,
  parameter int DEPTH   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_start,
  input  logic [ID_W-1:0]   slot_owner,
  input  logic              pr_push,
  input  logic [1:0]        pr_kind,
  input  logic [ADDR_W-1:0] pr_addr,
  output logic              pr_full,
  input  logic              wb_push,
  input  logic [ADDR_W-1:0] wb_addr,
  output logic              wb_full,
  output logic [ADDR_W-1:0] query_addr,
  input  logic              query_pending,
  output logic              bus_valid,
  output logic [1:0]        bus_kind,
  output logic [ADDR_W-1:0] bus_addr
);
  import srs_pkg::*;
  localparam int PR_W = ADDR_W + 2;

  logic              grant;
  logic [PR_W-1:0]   pr_head;
  logic [1:0]        pr_head_kind;
  logic [ADDR_W-1:0] pr_head_addr;
  logic [ADDR_W-1:0] wb_head_addr;
  logic              pr_empty, wb_empty;
  logic              upg_blocked, pr_ok, wb_ok;
  logic              send_pr, send_wb;
  logic              valid_d;
  logic [1:0]        kind_d;
  logic [ADDR_W-1:0] addr_d;

  assign grant = slot_start && (slot_owner == ID_W'(CORE_ID));

  srs_fifo #(.W(PR_W), .DEPTH(DEPTH)) pr_q_i (
    .clk(clk), .rst_n(rst_n),
    .push(pr_push), .din({pr_kind, pr_addr}),
    .pop(send_pr), .dout(pr_head),
    .empty(pr_empty), .full(pr_full)
  );

  srs_fifo #(.W(ADDR_W), .DEPTH(DEPTH)) wb_q_i (
    .clk(clk), .rst_n(rst_n),
    .push(wb_push), .din(wb_addr),
    .pop(send_wb), .dout(wb_head_addr),
    .empty(wb_empty), .full(wb_full)
  );

  assign pr_head_kind = pr_head[PR_W-1 -: 2];
  assign pr_head_addr = pr_head[ADDR_W-1:0];
  assign query_addr   = pr_head_addr;

  assign upg_blocked = (pr_head_kind == MSG_UPG) && query_pending;
  assign pr_ok       = !pr_empty && !upg_blocked;
  assign wb_ok       = !wb_empty;

  srs_pick pick_i (
    .clk(clk), .rst_n(rst_n), .grant(grant),
    .pr_ok(pr_ok), .wb_ok(wb_ok),
    .send_pr(send_pr), .send_wb(send_wb)
  );

  always_comb begin
    valid_d = send_pr || send_wb;
    kind_d  = bus_kind;
    addr_d  = bus_addr;
    if (send_wb) begin
      kind_d = MSG_WB;
      addr_d = wb_head_addr;
    end else if (send_pr) begin
      kind_d = pr_head_kind;
      addr_d = pr_head_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_valid <= 1'b0;
      bus_kind  <= 2'd0;
      bus_addr  <= '0;
    end else begin
      bus_valid <= valid_d;
      if (valid_d) begin
        bus_kind <= kind_d;
        bus_addr <= addr_d;
      end
    end
  end
endmodule

// File: rtl/srs_checker.sv
module srs_checker #(
  parameter int ID_W    = 2,
  parameter int CORE_ID = 0
) (
  input logic            clk,
  input logic            rst_n,
  input logic            slot_start,
  input logic [ID_W-1:0] slot_owner,
  input logic            query_pending,
  input logic            pr_empty,
  input logic            wb_empty,
  input logic            bus_valid,
  input logic [1:0]      bus_kind
);
  logic own;
  assign own = slot_start && (slot_owner == ID_W'(CORE_ID));

  // R1: messages only follow an owned slot
  a_r1_owned_slot_only: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> $past(own));

  // R6: queued write-back never loses an owned slot
  a_r6_wb_uses_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (own && !wb_empty) |=> bus_valid);

  // R7: an upgrade never goes out in a slot flagged pending
  a_r7_upg_not_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_kind == 2'd2) |-> !$past(query_pending));

  // R8: owned slot with both queues empty stays idle
  a_r8_idle_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (own && pr_empty && wb_empty) |=> !bus_valid);
endmodule

bind slot_req_sched srs_checker #(.ID_W(ID_W), .CORE_ID(CORE_ID)) chk_i (
  .clk(clk), .rst_n(rst_n), .slot_start(slot_start), .slot_owner(slot_owner),
  .query_pending(query_pending), .pr_empty(pr_empty), .wb_empty(wb_empty),
  .bus_valid(bus_valid), .bus_kind(bus_kind)
);

// File: tb/slot_req_sched_tb_top.sv
module slot_req_sched_tb_top;
  localparam int ID_W = 2, MYID = 2, AW = 8, DEP = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic slot_start = 1'b0, pr_push = 1'b0, wb_push = 1'b0, query_pending = 1'b0;
  logic [ID_W-1:0] slot_owner = '0;
  logic [1:0] pr_kind = '0;
  logic [AW-1:0] pr_addr = '0, wb_addr = '0;
  logic pr_full, wb_full, bus_valid;
  logic [AW-1:0] query_addr, bus_addr;
  logic [1:0] bus_kind;

  always #5 clk = ~clk;

  slot_req_sched #(.ID_W(ID_W), .CORE_ID(MYID), .ADDR_W(AW), .DEPTH(DEP)) dut_i (
    .clk(clk), .rst_n(rst_n), .slot_start(slot_start), .slot_owner(slot_owner),
    .pr_push(pr_push), .pr_kind(pr_kind), .pr_addr(pr_addr), .pr_full(pr_full),
    .wb_push(wb_push), .wb_addr(wb_addr), .wb_full(wb_full),
    .query_addr(query_addr), .query_pending(query_pending),
    .bus_valid(bus_valid), .bus_kind(bus_kind), .bus_addr(bus_addr));

  typedef struct { logic [1:0] k; logic [AW-1:0] a; } ent_t;
  typedef struct { logic v; logic [1:0] k; logic [AW-1:0] a; int due; string tag; } exp_t;

  ent_t m_pr[$];
  logic [AW-1:0] m_wb[$];
  logic m_turn = 1'b0;
  exp_t exp_q[$];
  int cyc = 0, total = 0, bad = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // monitor: compare bus output with scoreboard at each negedge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (exp_q.size() > 0 && exp_q[0].due == cyc) begin
        exp_t e;
        e = exp_q.pop_front();
        check({e.tag, " valid"}, bus_valid, e.v);
        if (e.v && bus_valid) begin
          check({e.tag, " kind"}, bus_kind, e.k);
          check({e.tag, " addr"}, bus_addr, e.a);
        end
      end else if (bus_valid) begin
        check("R1 unexpected message", 1, 0);
      end
    end
  end

  task automatic push_pr(input logic [1:0] k, input logic [AW-1:0] a);
    pr_push = 1'b1; pr_kind = k; pr_addr = a;
    if (m_pr.size() < DEP) m_pr.push_back('{k: k, a: a});
    @(negedge clk);
    pr_push = 1'b0;
  endtask

  task automatic push_wb(input logic [AW-1:0] a);
    wb_push = 1'b1; wb_addr = a;
    if (m_wb.size() < DEP) m_wb.push_back(a);
    @(negedge clk);
    wb_push = 1'b0;
  endtask

  task automatic slot(input int owner, input logic pend, input string tag);
    exp_t e;
    logic pr_ok, wb_ok, pick_wb;
    slot_start = 1'b1; slot_owner = owner[ID_W-1:0]; query_pending = pend;
    e.v = 1'b0; e.k = 2'd0; e.a = '0; e.due = cyc + 1; e.tag = tag;
    if (m_pr.size() > 0) begin
      #1 check("R10 query_addr", query_addr, m_pr[0].a);
    end
    if (owner == MYID) begin
      pr_ok = (m_pr.size() > 0) && !(m_pr[0].k == 2'd2 && pend);
      wb_ok = (m_wb.size() > 0);
      pick_wb = wb_ok && (m_turn || !pr_ok);
      if (pick_wb) begin
        e.v = 1'b1; e.k = 2'd3; e.a = m_wb.pop_front(); m_turn = 1'b0;
      end else if (pr_ok) begin
        ent_t h;
        h = m_pr.pop_front();
        e.v = 1'b1; e.k = h.k; e.a = h.a; m_turn = 1'b1;
      end
    end
    exp_q.push_back(e);
    @(negedge clk);
    slot_start = 1'b0; query_pending = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset bus_valid", bus_valid, 0);
    check("R11 reset pr_full", pr_full, 0);
    check("R11 reset wb_full", wb_full, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R8: foreign slot and empty owned slot
    slot(1, 0, "R1 foreign slot");
    slot(MYID, 0, "R8 empty owned slot");

    // R3 R4 R5: alternation with both queues loaded
    push_pr(2'd0, 8'h11);
    push_pr(2'd1, 8'h12);
    push_wb(8'hA1);
    push_wb(8'hA2);
    slot(MYID, 0, "R5 first turn request");
    slot(0, 0, "R1 other owner");
    slot(MYID, 0, "R5 then write-back");
    slot(3, 0, "R2 other owner no pop");
    slot(MYID, 0, "R3 second request");
    slot(MYID, 0, "R4 second write-back");

    // R6: only write-backs while request queue empty
    push_wb(8'hA3);
    push_wb(8'hA4);
    slot(MYID, 0, "R6 wb on request turn");
    slot(MYID, 0, "R6 wb again");

    // R7: blocked upgrade
    push_pr(2'd2, 8'h33);
    push_wb(8'hA5);
    slot(MYID, 1, "R7 blocked upgrade gives slot to wb");
    slot(MYID, 1, "R7 blocked upgrade idle");
    push_wb(8'hA6);
    slot(MYID, 0, "R8 turn kept after idle upgrade released");
    slot(MYID, 0, "R5 wb after upgrade");

    // R7: non-upgrade ignores pending flag
    push_pr(2'd1, 8'h44);
    slot(MYID, 1, "R7 getm ignores pending");

    // R9: fill both queues, extra push dropped
    for (int i = 0; i < 5; i++) begin
      push_pr(2'd0, 8'h50 + AW'(i));
      if (i == 3) check("R9 pr_full at 4", pr_full, 1);
    end
    for (int i = 0; i < 5; i++) begin
      push_wb(8'hB0 + AW'(i));
      if (i == 3) check("R9 wb_full at 4", wb_full, 1);
    end
    for (int i = 0; i < 10; i++) slot(MYID, 0, "R9 drain order");
    check("R9 pr_full after drain", pr_full, 0);
    check("R9 wb_full after drain", wb_full, 0);

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) check("R2 pending expectations", exp_q.size(), 0);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule